// File: doc/BRIEF.md
# Scan Code Set 2 Key Event Decoder

This block sits behind a keyboard frame receiver and turns the received byte stream into key events. It follows the byte-oriented encoding of scan code set 2. In that encoding a press is a bare code byte. A release is the same code after a break prefix (F0). Duplicated keys carry an extended prefix (E0). The pause key sends an eight-byte burst with no release. Each key event carries the 8-bit base code, an extended flag, a break flag and a pause flag. Protocol reply bytes from the keyboard are never reported as keys; they leave on a separate response port.

The decoder is a single state machine. Its states are `ST_IDLE` (no prefix pending), `ST_EXT` (E0 seen), `ST_BRK` (F0 seen), `ST_EXT_BRK` (E0 then F0 seen) and `ST_PAUSE` (inside the pause burst, with a byte index). Its transitions are:
- `ST_IDLE` to `ST_EXT` on E0.
- `ST_IDLE` to `ST_BRK` on F0.
- `ST_IDLE` to `ST_PAUSE` on E1.
- `ST_EXT` to `ST_EXT_BRK` on F0.
- Any prefix state back to `ST_IDLE` on a code byte, which emits the event.
- Any prefix state back to `ST_IDLE` on a misplaced prefix or reply byte, which raises the error pulse.
- `ST_PAUSE` stays in place while the burst matches, and returns to `ST_IDLE` after the last byte with a pause event, or on a mismatch with an error.

Every result is registered, so it appears one cycle after the byte that caused it, as a one-cycle strobe.

Top module: `kbd_sc2_decoder`

## Requirements
- R1: In `ST_IDLE`, a byte that is neither a prefix (E0, F0, E1) nor a reply byte produces a key event in the next cycle, with `ev_code` equal to that byte and `ev_ext`, `ev_brk` and `ev_pause` all 0.
- R2: The sequence F0, code produces a single key event with `ev_brk`=1, `ev_ext`=0 and `ev_code`=code. The F0 byte itself produces no output.
- R3: E0, code produces a key event with `ev_ext`=1 and `ev_brk`=0. E0, F0, code produces one with `ev_ext`=1 and `ev_brk`=1. The prefix bytes produce no output.
- R4: The burst E1 14 77 E1 F0 14 F0 77 produces exactly one key event, one cycle after its final byte. That event has `ev_pause`=1, `ev_code`=8'h77, `ev_ext`=0 and `ev_brk`=0. No output appears for the first seven bytes.
- R5: In `ST_IDLE`, the reply bytes AA, FC, FA, EE, FE, 00 and FF raise `rsp_valid` for one cycle with `rsp_code` equal to the byte, and never raise `ev_valid`.
- R6: In `ST_PAUSE`, a byte that differs from the expected burst byte raises `err_pulse` for one cycle with no event. It also returns the machine to `ST_IDLE`, so the next byte is decoded from scratch.
- R7: While E0 or F0 is pending, the following bytes raise `err_pulse`, clear the prefix and emit no key or response: a reply byte, E1, a second F0, or E0 after E0 or after F0.
- R8: The prefix state clears after every event. Repeated identical code bytes with no break in between (typematic repeat) each give their own make event.
- R9: The print-screen press E0 12 E0 7C yields two extended make events, with codes 12 and then 7C.
- R10: After reset all outputs are 0. A cycle with `byte_valid` low changes no state, whatever `byte_data` holds. At most one of `ev_valid`, `rsp_valid` and `err_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| ev_valid | output | 1 | One-cycle key event strobe |
| ev_code | output | 8 | Base scan code of the event |
| ev_ext | output | 1 | Event carried the E0 prefix |
| ev_brk | output | 1 | Event is a release |
| ev_pause | output | 1 | Event is the pause key |
| rsp_valid | output | 1 | One-cycle reply byte strobe |
| rsp_code | output | 8 | Reply byte value |
| err_pulse | output | 1 | One-cycle protocol error strobe |

## Verification
The assertions assume that `byte_valid` is low throughout reset. They also assume that a result can be traced back to the byte presented exactly one cycle earlier. The stimulus meets both conditions: it holds the strobe low during reset and presents each byte for a single cycle, followed by an idle cycle. During those idle cycles it puts prefix and reply values on `byte_data`, so the quiet-cycle properties are exercised with data that would matter if it were wrongly accepted.

// File: rtl/kbd_sc2_pkg.sv
package kbd_sc2_pkg;

    localparam int BYTE_W    = 8;
    localparam int PAUSE_LEN = 8;
    localparam int PIDX_W    = $clog2(PAUSE_LEN);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PIDX_W-1:0] pidx_t;

    localparam byte_t PFX_EXT   = 8'hE0;
    localparam byte_t PFX_BRK   = 8'hF0;
    localparam byte_t PFX_PAUSE = 8'hE1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_BRK,
        ST_EXT_BRK,
        ST_PAUSE
    } dec_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_KEY,
        EV_RSP,
        EV_ERR
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e kind;
        byte_t    code;
        logic     ext;
        logic     brk;
        logic     pause;
    } dec_ev_t;

    // Keyboard reply bytes that never count as key codes
    function automatic logic is_reply(byte_t b);
        case (b)
            8'hAA, 8'hFC, 8'hFA, 8'hEE, 8'hFE, 8'h00, 8'hFF: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    // Expected byte at each position of the pause burst
    function automatic byte_t pause_byte(pidx_t i);
        case (i)
            3'd0:    return 8'hE1;
            3'd1:    return 8'h14;
            3'd2:    return 8'h77;
            3'd3:    return 8'hE1;
            3'd4:    return 8'hF0;
            3'd5:    return 8'h14;
            3'd6:    return 8'hF0;
            default: return 8'h77;
        endcase
    endfunction

endpackage

// File: rtl/kbd_sc2_classify.sv
module kbd_sc2_classify
    import kbd_sc2_pkg::*;
(
    input  byte_t in_byte,
    output logic  c_ext,
    output logic  c_brk,
    output logic  c_pause,
    output logic  c_reply
);

    always_comb begin
        c_ext   = (in_byte == PFX_EXT);
        c_brk   = (in_byte == PFX_BRK);
        c_pause = (in_byte == PFX_PAUSE);
        c_reply = is_reply(in_byte);
    end

endmodule

// File: rtl/kbd_sc2_fsm.sv
module kbd_sc2_fsm
    import kbd_sc2_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  byte_t   in_byte,
    input  logic    c_ext,
    input  logic    c_brk,
    input  logic    c_pause,
    input  logic    c_reply,
    output dec_ev_t ev
);

    localparam pidx_t LAST_IDX = pidx_t'(PAUSE_LEN - 1);

    dec_state_e st, st_n;
    pidx_t      idx, idx_n;
    logic       misplaced;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    assign misplaced = c_ext | c_brk | c_pause | c_reply;

    // Next state and event decode
    always_comb begin
        st_n     = st;
        idx_n    = idx;
        ev.kind  = EV_NONE;
        ev.code  = in_byte;
        ev.ext   = 1'b0;
        ev.brk   = 1'b0;
        ev.pause = 1'b0;
        if (in_valid) begin
            unique case (st)
                ST_IDLE: begin
                    if (c_ext) begin
                        st_n = ST_EXT;
                    end else if (c_brk) begin
                        st_n = ST_BRK;
                    end else if (c_pause) begin
                        st_n  = ST_PAUSE;
                        idx_n = pidx_t'(1);
                    end else if (c_reply) begin
                        ev.kind = EV_RSP;
                    end else begin
                        ev.kind = EV_KEY;
                    end
                end
                ST_EXT: begin
                    if (c_brk) begin
                        st_n = ST_EXT_BRK;
                    end else if (misplaced) begin
                        ev.kind = EV_ERR;
                        st_n    = ST_IDLE;
                    end else begin
                        ev.kind = EV_KEY;
                        ev.ext  = 1'b1;
                        st_n    = ST_IDLE;
                    end
                end
                ST_BRK, ST_EXT_BRK: begin
                    st_n = ST_IDLE;
                    if (misplaced) begin
                        ev.kind = EV_ERR;
                    end else begin
                        ev.kind = EV_KEY;
                        ev.brk  = 1'b1;
                        ev.ext  = (st == ST_EXT_BRK);
                    end
                end
                ST_PAUSE: begin
                    if (in_byte != pause_byte(idx)) begin
                        ev.kind = EV_ERR;
                        st_n    = ST_IDLE;
                        idx_n   = '0;
                    end else if (idx == LAST_IDX) begin
                        ev.kind  = EV_KEY;
                        ev.pause = 1'b1;
                        ev.code  = pause_byte(LAST_IDX);
                        st_n     = ST_IDLE;
                        idx_n    = '0;
                    end else begin
                        idx_n = idx + pidx_t'(1);
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    idx_n = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/kbd_sc2_outreg.sv
module kbd_sc2_outreg
    import kbd_sc2_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  dec_ev_t ev,
    output logic    ev_valid,
    output byte_t   ev_code,
    output logic    ev_ext,
    output logic    ev_brk,
    output logic    ev_pause,
    output logic    rsp_valid,
    output byte_t   rsp_code,
    output logic    err_pulse
);

    logic is_key;
    assign is_key = (ev.kind == EV_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid  <= 1'b0;
            ev_code   <= '0;
            ev_ext    <= 1'b0;
            ev_brk    <= 1'b0;
            ev_pause  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            err_pulse <= 1'b0;
        end else begin
            ev_valid  <= is_key;
            ev_ext    <= is_key & ev.ext;
            ev_brk    <= is_key & ev.brk;
            ev_pause  <= is_key & ev.pause;
            rsp_valid <= (ev.kind == EV_RSP);
            err_pulse <= (ev.kind == EV_ERR);
            if (is_key)
                ev_code <= ev.code;
            if (ev.kind == EV_RSP)
                rsp_code <= ev.code;
        end
    end

endmodule

// File: rtl/kbd_sc2_decoder.sv
module kbd_sc2_decoder
    import kbd_sc2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       ev_valid,
    output logic [7:0] ev_code,
    output logic       ev_ext,
    output logic       ev_brk,
    output logic       ev_pause,
    output logic       rsp_valid,
    output logic [7:0] rsp_code,
    output logic       err_pulse
);

    logic    c_ext, c_brk, c_pause, c_reply;
    dec_ev_t ev;

    kbd_sc2_classify u_cls (
        .in_byte (byte_data),
        .c_ext   (c_ext),
        .c_brk   (c_brk),
        .c_pause (c_pause),
        .c_reply (c_reply)
    );

    kbd_sc2_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (byte_valid),
        .in_byte  (byte_data),
        .c_ext    (c_ext),
        .c_brk    (c_brk),
        .c_pause  (c_pause),
        .c_reply  (c_reply),
        .ev       (ev)
    );

    kbd_sc2_outreg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .ev_valid  (ev_valid),
        .ev_code   (ev_code),
        .ev_ext    (ev_ext),
        .ev_brk    (ev_brk),
        .ev_pause  (ev_pause),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .err_pulse (err_pulse)
    );

endmodule

// File: rtl/kbd_sc2_decoder_chk.sv
module kbd_sc2_decoder_chk
    import kbd_sc2_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       ev_valid,
    input logic [7:0] ev_code,
    input logic       ev_ext,
    input logic       ev_brk,
    input logic       ev_pause,
    input logic       rsp_valid,
    input logic [7:0] rsp_code,
    input logic       err_pulse
);

    AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_valid, rsp_valid, err_pulse})); // R10

    AST_QUIET_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_valid) |-> !(ev_valid || rsp_valid || err_pulse)); // R10

    AST_KEY_CODE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_pause) |-> (ev_code == $past(byte_data))); // R1

    AST_PAUSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pause |-> (ev_valid && !ev_ext && !ev_brk && ev_code == 8'h77
                      && $past(byte_data) == 8'h77)); // R4

    AST_REPLY_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (is_reply(rsp_code) && rsp_code == $past(byte_data))); // R5

    AST_NO_REPLY_AS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_pause) |-> !is_reply(ev_code)); // R7

    AST_FLAGS_ONLY_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext || ev_brk || ev_pause) |-> ev_valid); // R3

endmodule

bind kbd_sc2_decoder kbd_sc2_decoder_chk u_chk (.*);

// File: tb/kbd_sc2_decoder_test.sv
module kbd_sc2_decoder_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       ev_valid, ev_ext, ev_brk, ev_pause, rsp_valid, err_pulse;
    logic [7:0] ev_code, rsp_code;

    int checks = 0;
    int fails = 0;
    int outs_seen = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 1 key, 2 reply, 3 error
        logic [7:0] code;
        logic       ext;
        logic       brk;
        logic       pause;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_sc2_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_ext(ev_ext), .ev_brk(ev_brk),
        .ev_pause(ev_pause), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .err_pulse(err_pulse)
    );

    task automatic push_key(input logic [7:0] c, input logic e, input logic b,
                            input logic p, input string r);
        exp_t it;
        it.kind = 1; it.code = c; it.ext = e; it.brk = b; it.pause = p; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic push_rsp(input logic [7:0] c, input string r);
        exp_t it;
        it.kind = 2; it.code = c; it.ext = 0; it.brk = 0; it.pause = 0; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic push_err(input string r);
        exp_t it;
        it.kind = 3; it.code = 0; it.ext = 0; it.brk = 0; it.pause = 0; it.req = r;
        exp_q.push_back(it);
    endtask

    // One byte for one cycle, then an idle cycle with junk on the data bus
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'hF0;
    endtask

    // Monitor: pops one expectation per observed output
    always @(negedge clk) begin
        if (mon_en && (ev_valid || rsp_valid || err_pulse)) begin
            int         a_kind;
            logic [7:0] a_code;
            exp_t       it;
            outs_seen++;
            a_kind = ev_valid ? 1 : (rsp_valid ? 2 : 3);
            a_code = ev_valid ? ev_code : (rsp_valid ? rsp_code : 8'h00);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected output: kind=%0d code=%02h expected none", a_kind, a_code);
            end else begin
                it = exp_q.pop_front();
                if (a_kind != it.kind || a_code != it.code ||
                    (a_kind == 1 && (ev_ext != it.ext || ev_brk != it.brk || ev_pause != it.pause))) begin
                    fails++;
                    $display("FAIL %s: got kind=%0d code=%02h ext=%b brk=%b pause=%b, expected kind=%0d code=%02h ext=%b brk=%b pause=%b",
                             it.req, a_kind, a_code, ev_ext, ev_brk, ev_pause,
                             it.kind, it.code, it.ext, it.brk, it.pause);
                end
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
        end
    end

    initial begin
        int seen_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        checks++;
        if (ev_valid || rsp_valid || err_pulse || ev_ext || ev_brk || ev_pause) begin
            fails++;
            $display("FAIL R10 reset: got ev=%b rsp=%b err=%b, expected all 0",
                     ev_valid, rsp_valid, err_pulse);
        end
        mon_en = 1'b1;

        // R1: plain make
        push_key(8'h1C, 0, 0, 0, "R1 plain make");
        send_byte(8'h1C);
        push_key(8'h83, 0, 0, 0, "R1 plain make high code");
        send_byte(8'h83);

        // R2: break
        push_key(8'h1C, 0, 1, 0, "R2 break");
        send_byte(8'hF0); send_byte(8'h1C);

        // R3: extended make and break
        push_key(8'h14, 1, 0, 0, "R3 ext make");
        send_byte(8'hE0); send_byte(8'h14);
        push_key(8'h14, 1, 1, 0, "R3 ext break");
        send_byte(8'hE0); send_byte(8'hF0); send_byte(8'h14);

        // R8: typematic repeat and prefix clearing
        for (int i = 0; i < 3; i++) begin
            push_key(8'h23, 0, 0, 0, "R8 repeat make");
            send_byte(8'h23);
        end
        push_key(8'h23, 0, 1, 0, "R8 break then");
        send_byte(8'hF0); send_byte(8'h23);
        push_key(8'h23, 0, 0, 0, "R8 prefix cleared");
        send_byte(8'h23);

        // R9: print screen press
        push_key(8'h12, 1, 0, 0, "R9 prtsc first");
        push_key(8'h7C, 1, 0, 0, "R9 prtsc second");
        send_byte(8'hE0); send_byte(8'h12); send_byte(8'hE0); send_byte(8'h7C);

        // R4: pause burst gives one event
        push_key(8'h77, 0, 0, 1, "R4 pause");
        send_byte(8'hE1); send_byte(8'h14); send_byte(8'h77); send_byte(8'hE1);
        send_byte(8'hF0); send_byte(8'h14); send_byte(8'hF0); send_byte(8'h77);
        push_key(8'h1C, 0, 0, 0, "R4 after pause");
        send_byte(8'h1C);

        // R5: reply bytes
        push_rsp(8'hAA, "R5 selftest ok");   send_byte(8'hAA);
        push_rsp(8'hFC, "R5 selftest fail"); send_byte(8'hFC);
        push_rsp(8'hFA, "R5 ack");           send_byte(8'hFA);
        push_rsp(8'hEE, "R5 echo");          send_byte(8'hEE);
        push_rsp(8'hFE, "R5 resend");        send_byte(8'hFE);
        push_rsp(8'h00, "R5 overflow 00");   send_byte(8'h00);
        push_rsp(8'hFF, "R5 overflow FF");   send_byte(8'hFF);

        // R6: broken pause bursts
        push_err("R6 early mismatch");
        send_byte(8'hE1); send_byte(8'h14); send_byte(8'h33);
        push_key(8'h1C, 0, 0, 0, "R6 fresh after error");
        send_byte(8'h1C);
        push_err("R6 last byte mismatch");
        send_byte(8'hE1); send_byte(8'h14); send_byte(8'h77); send_byte(8'hE1);
        send_byte(8'hF0); send_byte(8'h14); send_byte(8'hF0); send_byte(8'h76);
        push_key(8'h76, 0, 0, 0, "R6 fresh after late error");
        send_byte(8'h76);

        // R7: misplaced bytes while a prefix is pending
        push_err("R7 reply after E0");  send_byte(8'hE0); send_byte(8'hFA);
        push_err("R7 E0 after F0");     send_byte(8'hF0); send_byte(8'hE0);
        push_err("R7 F0 after F0");     send_byte(8'hF0); send_byte(8'hF0);
        push_err("R7 E1 after E0");     send_byte(8'hE0); send_byte(8'hE1);
        push_err("R7 E0 after E0");     send_byte(8'hE0); send_byte(8'hE0);
        push_err("R7 reply after E0 F0");
        send_byte(8'hE0); send_byte(8'hF0); send_byte(8'hAA);
        push_key(8'h1C, 0, 0, 0, "R7 cleared");
        send_byte(8'h1C);

        // R10: bytes with valid low are ignored
        repeat (3) @(negedge clk);
        seen_before = outs_seen;
        @(negedge clk); byte_data = 8'hE1;
        @(negedge clk); byte_data = 8'hAA;
        @(negedge clk); byte_data = 8'hF0;
        @(negedge clk); byte_data = 8'h00;
        @(negedge clk);
        checks++;
        if (outs_seen != seen_before) begin
            fails++;
            $display("FAIL R10 ignored bytes: got %0d outputs, expected 0", outs_seen - seen_before);
        end
        push_key(8'h1C, 0, 0, 0, "R10 state untouched");
        send_byte(8'h1C);

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL missing outputs: got %0d pending, expected 0", exp_q.size());
        end
        done = 1'b1;
        report();
    end

endmodule